// File: doc/BRIEF.md
# Indirect Configuration Access Window

This block is a small host-side register window. It lets a host reach the configuration space and the I/O-port space of a downstream bus through two steps. First the host stores an address token in an address register. Then it reads or writes one of two data windows. An access to the configuration window starts a configuration cycle. An access to the I/O window starts an I/O-port cycle. The low two bits of the host address, together with the access size, decide which byte lanes the downstream cycle uses.

A downstream cycle is a request held until the target acknowledges it. The host access stalls until then: the ready pulse and the read data come only after the acknowledge. If the target stays silent for a fixed number of cycles, the block ends the cycle by itself. A read then returns all ones and the error flag is raised.

Some hosts issue a dummy configuration read before a configuration write. For that read the low byte of the token is cleared. This keeps the downstream bus from being driven one cycle too early. The window treats that read as an ordinary, harmless read cycle.

Top module: `icw_window`

## Requirements
- R1: After reset, host_ready, dn_req and host_err are 0, and a read of the address register returns 0.
- R2: The address register sits at host offset 0x064 and always stores the full 32-bit host write data, whatever the access size. A read of it returns the stored token. An access to it never starts a downstream cycle, and host_ready pulses for one cycle, one cycle after the request is taken.
- R3: An access at offset 0x068 starts a configuration cycle (dn_io = 0). dn_addr is {8'h00, token[23:2], 2'b00}. In this address, bits 23:16 carry the bus number, bits 15:8 carry the device/function, and bits 7:2 carry the register dword.
- R4: An access at offset 0x06C starts an I/O-port cycle (dn_io = 1). dn_addr is {16'h0000, token[15:2], 2'b00}, where token[15:0] holds the port address.
- R5: host_size encodes 0 = byte, 1 = 16-bit, 2 = 32-bit, and 3 counts as 32-bit. The byte enables are set as follows:
  - A byte access enables lane host_addr[1:0].
  - A 16-bit access enables 4'b1100 when host_addr[1] is 1, and 4'b0011 otherwise.
  - A 32-bit access enables 4'b1111.
- R6: On a write, dn_we is 1 and dn_wdata carries host_wdata. On a read, dn_we is 0. A dummy configuration read whose token has its low byte cleared produces a single read cycle and leaves the address register unchanged.
- R7: host_ready stays 0 while the downstream cycle waits, and pulses in the cycle after the acknowledge edge. Read data is dn_rdata with the lanes that are not enabled forced to 0. dn_req drops after the acknowledge.
- R8: If no acknowledge arrives within TIMEOUT (default 16) cycles of dn_req, the cycle ends. host_ready pulses, a read returns 32'hFFFFFFFF, and host_err becomes 1.
- R9: An acknowledge in the last allowed cycle completes the access normally, with its data and host_err 0.
- R10: host_err returns to 0 when a later downstream cycle is acknowledged.
- R11: An access to any other offset completes in one cycle with read data 0. It starts no downstream cycle and changes nothing.
- R12: While dn_req is high and unacknowledged, dn_addr, dn_be, dn_we, dn_io and dn_wdata stay constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, held until host_ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Host byte address |
| host_size | input | 2 | Access size code |
| host_wdata | input | 32 | Host write data, in its byte lanes |
| host_rdata | output | 32 | Read data, valid while host_ready is high |
| host_ready | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | Last downstream cycle timed out |
| dn_req | output | 1 | Downstream cycle request |
| dn_io | output | 1 | 1 = I/O-port cycle, 0 = configuration cycle |
| dn_we | output | 1 | Downstream write |
| dn_addr | output | 32 | Downstream dword address |
| dn_be | output | 4 | Active-high byte enables |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data |
| dn_ack | input | 1 | Downstream acknowledge |

## Verification
Two events can fall in the same cycle: the target's acknowledge and the expiry of the timeout counter. The bench provokes this with a downstream model that acknowledges exactly in the last allowed cycle. It then checks three things: the read returns the model's data and not all ones, host_err clears, and the ready latency equals the full window. Runs with a delay one cycle longer, and with no response at all, show the timeout side taking over.

// File: rtl/icw_pkg.sv
package icw_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_ADDR,
        RG_CFG,
        RG_IO
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUS,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic              io;
        logic              we;
        logic [DATA_W-1:0] addr;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
    } dn_cmd_t;

    function automatic logic [LANES-1:0] lane_enables(size_e sz, logic [1:0] lo);
        case (sz)
            SZ_BYTE: lane_enables = LANES'(1) << lo;
            SZ_HALF: lane_enables = lo[1] ? 4'b1100 : 4'b0011;
            default: lane_enables = 4'b1111;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(logic [LANES-1:0] be);
        for (int i = 0; i < LANES; i++) begin
            lane_mask[i*8 +: 8] = {8{be[i]}};
        end
    endfunction

endpackage

// File: rtl/icw_decode.sv
module icw_decode
    import icw_pkg::*;
#(
    parameter int             AW       = 12,
    parameter logic [AW-1:0]  ADDR_OFF = 12'h064,
    parameter logic [AW-1:0]  CFG_OFF  = 12'h068,
    parameter logic [AW-1:0]  IO_OFF   = 12'h06C
) (
    input  logic [AW-1:0]    addr,
    input  logic [1:0]       size,
    output region_e          region,
    output logic [LANES-1:0] be
);
    always_comb begin
        if (addr[AW-1:2] == ADDR_OFF[AW-1:2])      region = RG_ADDR;
        else if (addr[AW-1:2] == CFG_OFF[AW-1:2])  region = RG_CFG;
        else if (addr[AW-1:2] == IO_OFF[AW-1:2])   region = RG_IO;
        else                                       region = RG_NONE;
    end

    assign be = lane_enables(size_e'(size), addr[1:0]);
endmodule

// File: rtl/icw_timer.sv
module icw_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + CW'(1);
    end

    assign expire = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/icw_window.sv
module icw_window
    import icw_pkg::*;
#(
    parameter int            AW       = 12,
    parameter logic [AW-1:0] ADDR_OFF = 12'h064,
    parameter logic [AW-1:0] CFG_OFF  = 12'h068,
    parameter logic [AW-1:0] IO_OFF   = 12'h06C,
    parameter int            TIMEOUT  = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_req,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [1:0]    host_size,
    input  logic [31:0]   host_wdata,
    output logic [31:0]   host_rdata,
    output logic          host_ready,
    output logic          host_err,
    output logic          dn_req,
    output logic          dn_io,
    output logic          dn_we,
    output logic [31:0]   dn_addr,
    output logic [3:0]    dn_be,
    output logic [31:0]   dn_wdata,
    input  logic [31:0]   dn_rdata,
    input  logic          dn_ack
);
    state_e            st;
    region_e           region;
    logic [LANES-1:0]  be_dec;
    logic [DATA_W-1:0] token;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;
    logic              expire;
    dn_cmd_t           cmd;

    icw_decode #(
        .AW(AW), .ADDR_OFF(ADDR_OFF), .CFG_OFF(CFG_OFF), .IO_OFF(IO_OFF)
    ) u_decode (
        .addr   (host_addr),
        .size   (host_size),
        .region (region),
        .be     (be_dec)
    );

    icw_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (st == ST_BUS),
        .expire (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            token   <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
            cmd     <= '0;
        end else begin
            case (st)
                ST_IDLE: if (host_req) begin
                    case (region)
                        RG_ADDR: begin
                            if (host_we) token <= host_wdata;
                            rdata_q <= host_we ? '0 : token;
                            st      <= ST_DONE;
                        end
                        RG_CFG, RG_IO: begin
                            cmd.io    <= (region == RG_IO);
                            cmd.we    <= host_we;
                            cmd.addr  <= (region == RG_IO)
                                         ? {16'h0000, token[15:2], 2'b00}
                                         : {8'h00, token[23:2], 2'b00};
                            cmd.be    <= be_dec;
                            cmd.wdata <= host_wdata;
                            st        <= ST_BUS;
                        end
                        default: begin
                            rdata_q <= '0;
                            st      <= ST_DONE;
                        end
                    endcase
                end
                ST_BUS: begin
                    if (dn_ack) begin
                        rdata_q <= cmd.we ? '0 : (dn_rdata & lane_mask(cmd.be));
                        err_q   <= 1'b0;
                        st      <= ST_DONE;
                    end else if (expire) begin
                        rdata_q <= cmd.we ? '0 : '1;
                        err_q   <= 1'b1;
                        st      <= ST_DONE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign host_ready = (st == ST_DONE);
    assign host_rdata = rdata_q;
    assign host_err   = err_q;
    assign dn_req     = (st == ST_BUS);
    assign dn_io      = cmd.io;
    assign dn_we      = cmd.we;
    assign dn_addr    = cmd.addr;
    assign dn_be      = cmd.be;
    assign dn_wdata   = cmd.wdata;
endmodule

// File: rtl/icw_window_chk.sv
module icw_window_chk (
    input logic        clk,
    input logic        rst,
    input logic        host_req,
    input logic        host_we,
    input logic        host_ready,
    input logic        host_err,
    input logic        dn_req,
    input logic        dn_io,
    input logic        dn_we,
    input logic [31:0] dn_addr,
    input logic [3:0]  dn_be,
    input logic [31:0] dn_wdata,
    input logic        dn_ack
);
    p_fields_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (dn_req && !dn_ack) |=> (host_ready || (dn_req && $stable(dn_addr) &&
            $stable(dn_be) && $stable(dn_we) && $stable(dn_io) && $stable(dn_wdata))));

    p_ack_completes_r7: assert property (@(posedge clk) disable iff (rst)
        (dn_req && dn_ack) |=> (host_ready && !dn_req));

    p_lanes_present_r5: assert property (@(posedge clk) disable iff (rst)
        dn_req |-> (dn_be != 4'b0000));

    p_read_no_write_r6: assert property (@(posedge clk) disable iff (rst)
        (dn_req && host_req && !host_we) |-> !dn_we);

    p_err_with_ready_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(host_err) |-> host_ready);

    p_ready_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        host_ready |=> !host_ready);
endmodule

bind icw_window icw_window_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_req   (host_req),
    .host_we    (host_we),
    .host_ready (host_ready),
    .host_err   (host_err),
    .dn_req     (dn_req),
    .dn_io      (dn_io),
    .dn_we      (dn_we),
    .dn_addr    (dn_addr),
    .dn_be      (dn_be),
    .dn_wdata   (dn_wdata),
    .dn_ack     (dn_ack)
);

// File: tb/icw_window_test.sv
module icw_window_test;
    localparam int AW      = 12;
    localparam int TIMEOUT = 16;
    localparam logic [AW-1:0] A_TOK = 12'h064;
    localparam logic [AW-1:0] A_CFG = 12'h068;
    localparam logic [AW-1:0] A_IO  = 12'h06C;

    logic          clk = 0;
    logic          rst = 1;
    logic          host_req = 0;
    logic          host_we = 0;
    logic [AW-1:0] host_addr = '0;
    logic [1:0]    host_size = 2'd2;
    logic [31:0]   host_wdata = '0;
    logic [31:0]   host_rdata;
    logic          host_ready;
    logic          host_err;
    logic          dn_req, dn_io, dn_we;
    logic [31:0]   dn_addr, dn_wdata;
    logic [3:0]    dn_be;
    logic [31:0]   dn_rdata = '0;
    logic          dn_ack = 0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    int          rsp_delay = 0;
    int          seen_cnt  = 0;
    int          dn_starts = 0;
    int          dn_acks   = 0;
    logic        c_io, c_we;
    logic [31:0] c_addr, c_wdata;
    logic [3:0]  c_be;

    icw_window #(.AW(AW), .TIMEOUT(TIMEOUT)) uut (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_size(host_size), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_ready(host_ready), .host_err(host_err),
        .dn_req(dn_req), .dn_io(dn_io), .dn_we(dn_we), .dn_addr(dn_addr),
        .dn_be(dn_be), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .dn_ack(dn_ack)
    );

    always #10 clk = ~clk;

    // downstream target model: acknowledges in cycle rsp_delay of dn_req
    always @(negedge clk) begin
        if (dn_req) begin
            if (seen_cnt == 0) begin
                dn_starts++;
                c_io = dn_io; c_we = dn_we; c_addr = dn_addr;
                c_be = dn_be; c_wdata = dn_wdata;
            end
            if (seen_cnt == rsp_delay) begin
                dn_ack = 1'b1;
                dn_acks++;
            end else begin
                dn_ack = 1'b0;
            end
            seen_cnt++;
        end else begin
            dn_ack   = 1'b0;
            seen_cnt = 0;
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cyc);
            finish_run();
        end
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [AW-1:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd, output int lat);
        @(negedge clk);
        host_we = we; host_addr = a; host_size = sz; host_wdata = wd; host_req = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!host_ready && lat < 200);
        rd = host_rdata;
        host_req = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] rd; int lat;
        check(host_ready == 0, "R1 ready after reset", 32'(host_ready), 0);
        check(dn_req == 0, "R1 dn_req after reset", 32'(dn_req), 0);
        check(host_err == 0, "R1 err after reset", 32'(host_err), 0);
        access(0, A_TOK, 2, 0, rd, lat);
        check(rd == 0, "R1 token reset value", rd, 0);
    endtask

    task automatic t_token_reg();
        logic [31:0] rd; int lat; int s0;
        s0 = dn_starts;
        access(1, A_TOK, 0, 32'hAB3A513C, rd, lat);
        check(lat == 1, "R2 token write latency", lat, 1);
        access(0, A_TOK + 12'd1, 0, 0, rd, lat);
        check(rd == 32'hAB3A513C, "R2 token readback (byte size, full word)", rd, 32'hAB3A513C);
        check(dn_starts == s0, "R2 no downstream cycle", dn_starts, s0);
    endtask

    task automatic t_cfg_read();
        logic [31:0] rd; int lat;
        rsp_delay = 3; dn_rdata = 32'hCAFEF00D;
        access(0, A_CFG, 2, 0, rd, lat);
        check(c_io == 0 && c_we == 0, "R3 cfg read kind", {c_io, c_we}, 0);
        check(c_addr == 32'h003A513C, "R3 cfg address from token", c_addr, 32'h003A513C);
        check(c_be == 4'hF, "R5 word lanes", c_be, 4'hF);
        check(rd == 32'hCAFEF00D, "R7 read data", rd, 32'hCAFEF00D);
        check(lat == 5, "R7 stall until ack", lat, 5);
        rsp_delay = 0; dn_rdata = 32'h11223344;
        access(0, A_CFG + 12'd2, 0, 0, rd, lat);
        check(c_be == 4'h4, "R5 byte lane 2", c_be, 4'h4);
        check(rd == 32'h00220000, "R7 masked lanes", rd, 32'h00220000);
    endtask

    task automatic t_io_write();
        logic [31:0] rd; int lat;
        rsp_delay = 1;
        access(1, A_TOK, 2, 32'h000003F9, rd, lat);
        access(1, A_IO + 12'd1, 0, 32'h0000AB00, rd, lat);
        check(c_io == 1, "R4 io kind", c_io, 1);
        check(c_addr == 32'h000003F8, "R4 io port address", c_addr, 32'h000003F8);
        check(c_we == 1 && c_wdata == 32'h0000AB00, "R6 write data", c_wdata, 32'h0000AB00);
        check(c_be == 4'h2, "R5 byte lane 1", c_be, 4'h2);
        access(1, A_IO + 12'd2, 1, 32'h12340000, rd, lat);
        check(c_be == 4'hC, "R5 upper half", c_be, 4'hC);
        access(1, A_IO, 1, 32'h00005678, rd, lat);
        check(c_be == 4'h3, "R5 lower half", c_be, 4'h3);
        access(1, A_IO + 12'd3, 0, 32'h9A000000, rd, lat);
        check(c_be == 4'h8, "R5 byte lane 3", c_be, 4'h8);
        access(1, A_IO, 3, 32'h01020304, rd, lat);
        check(c_be == 4'hF, "R5 reserved size as word", c_be, 4'hF);
    endtask

    task automatic t_dummy_read();
        logic [31:0] rd; int lat; int s0;
        rsp_delay = 2; dn_rdata = 32'h103C1234;
        access(1, A_TOK, 2, 32'h00125600, rd, lat);
        s0 = dn_starts;
        access(0, A_CFG, 2, 0, rd, lat);
        check(dn_starts == s0 + 1, "R6 dummy read single cycle", dn_starts, s0 + 1);
        check(c_we == 0 && c_addr == 32'h00125600, "R6 dummy read is a read", c_addr, 32'h00125600);
        access(0, A_TOK, 2, 0, rd, lat);
        check(rd == 32'h00125600, "R6 token kept after dummy read", rd, 32'h00125600);
        access(1, A_TOK, 2, 32'h00125610, rd, lat);
        access(1, A_CFG, 2, 32'hDEADBEEF, rd, lat);
        check(c_we == 1 && c_addr == 32'h00125610, "R6 following cfg write", c_addr, 32'h00125610);
    endtask

    task automatic t_timeout_and_clear();
        logic [31:0] rd; int lat; int a0;
        rsp_delay = 1000; a0 = dn_acks;
        access(0, A_CFG, 2, 0, rd, lat);
        check(rd == 32'hFFFFFFFF, "R8 timeout read value", rd, 32'hFFFFFFFF);
        check(host_err == 1, "R8 error flag", host_err, 1);
        check(lat == TIMEOUT + 1, "R8 timeout latency", lat, TIMEOUT + 1);
        check(dn_acks == a0, "R8 no ack seen", dn_acks, a0);
        @(negedge clk);
        check(dn_req == 0, "R8 request dropped", dn_req, 0);
        rsp_delay = 2; dn_rdata = 32'h55AA55AA;
        access(0, A_CFG, 2, 0, rd, lat);
        check(host_err == 0, "R10 error cleared by ack", host_err, 0);
        check(rd == 32'h55AA55AA, "R10 data after clear", rd, 32'h55AA55AA);
    endtask

    task automatic t_boundary();
        logic [31:0] rd; int lat;
        rsp_delay = 1000;
        access(1, A_IO, 2, 32'h0, rd, lat);
        check(host_err == 1, "R8 write timeout flag", host_err, 1);
        rsp_delay = TIMEOUT - 1; dn_rdata = 32'h0BADCAFE;
        access(0, A_CFG, 2, 0, rd, lat);
        check(rd == 32'h0BADCAFE, "R9 last-cycle ack data", rd, 32'h0BADCAFE);
        check(host_err == 0, "R9 last-cycle ack no error", host_err, 0);
        check(lat == TIMEOUT + 1, "R9 last-cycle latency", lat, TIMEOUT + 1);
        rsp_delay = TIMEOUT;
        access(0, A_CFG, 2, 0, rd, lat);
        check(rd == 32'hFFFFFFFF, "R9 one cycle late times out", rd, 32'hFFFFFFFF);
    endtask

    task automatic t_unmapped();
        logic [31:0] rd, tk; int lat; int s0;
        access(0, A_TOK, 2, 0, tk, lat);
        s0 = dn_starts;
        access(0, 12'h100, 2, 0, rd, lat);
        check(rd == 0 && lat == 1, "R11 unmapped read", rd, 0);
        access(1, 12'h070, 2, 32'hFFFF0000, rd, lat);
        access(0, A_TOK, 2, 0, rd, lat);
        check(rd == tk, "R11 unmapped write ignored", rd, tk);
        check(dn_starts == s0, "R11 no downstream cycle", dn_starts, s0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_token_reg();
        t_cfg_read();
        t_io_write();
        t_dummy_read();
        t_timeout_and_clear();
        t_boundary();
        t_unmapped();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule